// File: doc/BRIEF.md
# High-Speed DAC Bring-Up Sequencer

This block takes a high-speed DAC from reset to a fully locked state without software help. As soon as reset is released it sends a fixed chain of configuration register writes to the converter. It sends them through a simple command handshake towards an SPI serializer. It then enables the clock-phase (mu) tracking loop and waits a programmable number of data-clock cycles for that loop to settle. After the wait it reads the loop's status register to learn whether the loop has locked. Only once the mu loop is locked does it optionally rewrite the converter core settings, then enable the data-receiver controller and check that controller's lock in the same way.

Either lock stage can fail its check. A failed stage is configured again and waited on again, up to a fixed number of attempts. Running out of attempts, or a serializer that never acknowledges a command, parks the sequencer in a fault state. The fault state raises a sticky error flag and a code naming the stage that failed. A successful bring-up ends with a one-cycle done pulse. Lock can be reported by the status bit returned on a register read, or by an interrupt line pulsed during the settle window, and either is accepted.

Top module: `dac_bringup_seq`

## Requirements
- R1: After reset the commands leave in this order: port setup write, soft-reset write, clock common-mode write, mu-loop enable/track write, mu status read (spi_rnw=1). Each command uses its own address and value parameter.
- R2: A command is held on spi_req with stable spi_addr, spi_wdata and spi_rnw until a cycle with spi_ack high. Each acknowledged cycle completes exactly one command. spi_req stays low after done or error.
- R3: The first cycle of a status read request comes exactly SETTLE_CYC+1 cycles after the cycle in which the matching configuration write was acknowledged. This holds for both stages.
- R4: A status read passes when bit LOCK_BIT of spi_rdata is 1 on the acknowledge. It also passes when the stage's interrupt input (mu_irq or rx_irq) was high during that stage's settle or poll window since its last configuration write.
- R5: After the mu check passes, the core write follows, or it is skipped when core_bypass is 1. Then come the receiver configuration write and the receiver status read. No receiver command is sent before the mu check passes.
- R6: A failed check sends the same stage back to its configuration write. Each stage keeps its own attempt count, so failures of one stage do not use up the attempts of the other.
- R7: The third failed check of a stage ends the sequence with seq_err=1. fail_stage is then 1 for the mu stage or 2 for the receiver stage, and no further command is sent.
- R8: A command not acknowledged within ACK_TIMEOUT cycles ends the sequence with seq_err=1 and fail_stage=3.
- R9: seq_done is high for exactly one cycle after the receiver check passes, and never after an error. seq_err stays high until reset.
- R10: During and right after reset seq_done=0, seq_err=0 and fail_stage=0 (none). fail_stage stays 0 whenever seq_err is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock |
| rst | input | 1 | Synchronous active-high reset |
| core_bypass | input | 1 | Skip the optional core rewrite |
| mu_irq | input | 1 | Mu-loop lock interrupt |
| rx_irq | input | 1 | Receiver lock interrupt |
| spi_req | output | 1 | Command pending |
| spi_rnw | output | 1 | 1 = read, 0 = write |
| spi_addr | output | AW | Register address |
| spi_wdata | output | DW | Write value (0 for reads) |
| spi_ack | input | 1 | Command completed this cycle |
| spi_rdata | input | DW | Read data, valid with spi_ack |
| seq_done | output | 1 | One-cycle pulse on full lock |
| seq_err | output | 1 | Sticky error flag |
| fail_stage | output | 2 | 0 none, 1 mu, 2 receiver, 3 command timeout |

## Verification
A corrupted step register shows at the ports no later than the next acknowledge, as a wrong address, value or read/write bit in the command stream. A skipped or repeated stage shows the same way. A wrong settle count moves the status read by one or more cycles against the acknowledged configuration write. A shared or non-clearing attempt count turns a recoverable two-stage run into a fault. Faulty lock evaluation shows as a missing or extra configuration write within one settle window.

// File: rtl/dac_bringup_pkg.sv
package dac_bringup_pkg;

    typedef enum logic [3:0] {
        ST_PORT_CFG,
        ST_SOFT_RST,
        ST_CLK_CMV,
        ST_MU_CFG,
        ST_MU_SETTLE,
        ST_MU_POLL,
        ST_CORE_CFG,
        ST_RX_CFG,
        ST_RX_SETTLE,
        ST_RX_POLL,
        ST_UP,
        ST_FAULT
    } bring_st_e;

    typedef enum logic [1:0] {
        FS_NONE = 2'd0,
        FS_MU   = 2'd1,
        FS_RX   = 2'd2,
        FS_SPI  = 2'd3
    } fail_stage_e;

    localparam int N_STAGES = 2;

    typedef struct packed {
        logic issue;
        logic rnw;
        logic poll;
        logic settle;
        logic stage;
    } step_info_t;

    function automatic step_info_t decode_step(bring_st_e s);
        step_info_t i;
        i = '0;
        unique case (s)
            ST_PORT_CFG, ST_SOFT_RST, ST_CLK_CMV, ST_MU_CFG, ST_CORE_CFG:
                i.issue = 1'b1;
            ST_RX_CFG: begin
                i.issue = 1'b1;
                i.stage = 1'b1;
            end
            ST_MU_SETTLE: i.settle = 1'b1;
            ST_RX_SETTLE: begin
                i.settle = 1'b1;
                i.stage  = 1'b1;
            end
            ST_MU_POLL: begin
                i.issue = 1'b1;
                i.rnw   = 1'b1;
                i.poll  = 1'b1;
            end
            ST_RX_POLL: begin
                i.issue = 1'b1;
                i.rnw   = 1'b1;
                i.poll  = 1'b1;
                i.stage = 1'b1;
            end
            default: i = '0;
        endcase
        return i;
    endfunction

    function automatic bring_st_e next_step(bring_st_e s, logic bypass);
        unique case (s)
            ST_PORT_CFG:  return ST_SOFT_RST;
            ST_SOFT_RST:  return ST_CLK_CMV;
            ST_CLK_CMV:   return ST_MU_CFG;
            ST_MU_CFG:    return ST_MU_SETTLE;
            ST_MU_SETTLE: return ST_MU_POLL;
            ST_MU_POLL:   return bypass ? ST_RX_CFG : ST_CORE_CFG;
            ST_CORE_CFG:  return ST_RX_CFG;
            ST_RX_CFG:    return ST_RX_SETTLE;
            ST_RX_SETTLE: return ST_RX_POLL;
            ST_RX_POLL:   return ST_UP;
            default:      return s;
        endcase
    endfunction

    function automatic bring_st_e stage_cfg(logic stage);
        return stage ? ST_RX_CFG : ST_MU_CFG;
    endfunction

    function automatic fail_stage_e stage_fail(logic stage);
        return stage ? FS_RX : FS_MU;
    endfunction

endpackage

// File: rtl/dac_bringup_timer.sv
module dac_bringup_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || ld) begin
            cnt <= ld_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/dac_bringup_tries.sv
module dac_bringup_tries #(
    parameter int TRIES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic bump,
    input  logic wipe,
    output logic final_try
);
    localparam int CW = $clog2(TRIES + 1);
    localparam logic [CW-1:0] LAST = CW'(TRIES - 1);

    logic [CW-1:0] fails;

    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            fails <= '0;
        end else if (bump && fails != CW'(TRIES)) begin
            fails <= fails + 1'b1;
        end
    end

    assign final_try = (fails == LAST);
endmodule

// File: rtl/dac_bringup_cmd_table.sv
module dac_bringup_cmd_table
    import dac_bringup_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8,
    parameter logic [AW-1:0] A_PORT  = 8'h00,
    parameter logic [DW-1:0] V_PORT  = 8'h18,
    parameter logic [AW-1:0] A_SRST  = 8'h01,
    parameter logic [DW-1:0] V_SRST  = 8'h80,
    parameter logic [AW-1:0] A_CMV   = 8'h0F,
    parameter logic [DW-1:0] V_CMV   = 8'h0F,
    parameter logic [AW-1:0] A_MUCFG = 8'h26,
    parameter logic [DW-1:0] V_MUCFG = 8'h8B,
    parameter logic [AW-1:0] A_MUST  = 8'h2A,
    parameter logic [AW-1:0] A_CORE  = 8'h08,
    parameter logic [DW-1:0] V_CORE  = 8'h34,
    parameter logic [AW-1:0] A_RXCFG = 8'h10,
    parameter logic [DW-1:0] V_RXCFG = 8'h83,
    parameter logic [AW-1:0] A_RXST  = 8'h21
) (
    input  bring_st_e     step,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata
);
    always_comb begin
        addr  = '0;
        wdata = '0;
        unique case (step)
            ST_PORT_CFG: begin addr = A_PORT;  wdata = V_PORT;  end
            ST_SOFT_RST: begin addr = A_SRST;  wdata = V_SRST;  end
            ST_CLK_CMV:  begin addr = A_CMV;   wdata = V_CMV;   end
            ST_MU_CFG:   begin addr = A_MUCFG; wdata = V_MUCFG; end
            ST_MU_POLL:  begin addr = A_MUST;                   end
            ST_CORE_CFG: begin addr = A_CORE;  wdata = V_CORE;  end
            ST_RX_CFG:   begin addr = A_RXCFG; wdata = V_RXCFG; end
            ST_RX_POLL:  begin addr = A_RXST;                   end
            default: begin addr = '0; wdata = '0; end
        endcase
    end
endmodule

// File: rtl/dac_bringup_seq.sv
module dac_bringup_seq
    import dac_bringup_pkg::*;
#(
    parameter int AW          = 8,
    parameter int DW          = 8,
    parameter int SETTLE_CYC  = 256,
    parameter int ACK_TIMEOUT = 64,
    parameter int LOCK_TRIES  = 3,
    parameter int LOCK_BIT    = 0,
    parameter logic [AW-1:0] A_PORT  = 8'h00,
    parameter logic [DW-1:0] V_PORT  = 8'h18,
    parameter logic [AW-1:0] A_SRST  = 8'h01,
    parameter logic [DW-1:0] V_SRST  = 8'h80,
    parameter logic [AW-1:0] A_CMV   = 8'h0F,
    parameter logic [DW-1:0] V_CMV   = 8'h0F,
    parameter logic [AW-1:0] A_MUCFG = 8'h26,
    parameter logic [DW-1:0] V_MUCFG = 8'h8B,
    parameter logic [AW-1:0] A_MUST  = 8'h2A,
    parameter logic [AW-1:0] A_CORE  = 8'h08,
    parameter logic [DW-1:0] V_CORE  = 8'h34,
    parameter logic [AW-1:0] A_RXCFG = 8'h10,
    parameter logic [DW-1:0] V_RXCFG = 8'h83,
    parameter logic [AW-1:0] A_RXST  = 8'h21
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          core_bypass,
    input  logic          mu_irq,
    input  logic          rx_irq,
    output logic          spi_req,
    output logic          spi_rnw,
    output logic [AW-1:0] spi_addr,
    output logic [DW-1:0] spi_wdata,
    input  logic          spi_ack,
    input  logic [DW-1:0] spi_rdata,
    output logic          seq_done,
    output logic          seq_err,
    output logic [1:0]    fail_stage
);
    localparam int SW = $clog2(SETTLE_CYC + 1);
    localparam int TW = $clog2(ACK_TIMEOUT + 1);
    localparam logic [SW-1:0] SETTLE_LD = SW'(SETTLE_CYC - 1);
    localparam logic [TW-1:0] ACK_LD    = TW'(ACK_TIMEOUT - 1);

    bring_st_e   st, nxt;
    fail_stage_e fail_q, nxt_fail;
    step_info_t  si;
    logic        err_q, done_q;
    logic        retime, settle_done, ack_expired;
    logic        lock_now, lock_pass, lock_miss;
    logic [N_STAGES-1:0] irq_in, irq_seen, last_try;

    assign si     = decode_step(st);
    assign irq_in = {rx_irq, mu_irq};
    assign retime = (nxt != st);

    // Stage lock is the polled bit or an interrupt seen in the stage window
    assign lock_now = spi_rdata[LOCK_BIT] | irq_seen[si.stage] | irq_in[si.stage];

    dac_bringup_cmd_table #(
        .AW(AW), .DW(DW),
        .A_PORT(A_PORT), .V_PORT(V_PORT), .A_SRST(A_SRST), .V_SRST(V_SRST),
        .A_CMV(A_CMV), .V_CMV(V_CMV), .A_MUCFG(A_MUCFG), .V_MUCFG(V_MUCFG),
        .A_MUST(A_MUST), .A_CORE(A_CORE), .V_CORE(V_CORE),
        .A_RXCFG(A_RXCFG), .V_RXCFG(V_RXCFG), .A_RXST(A_RXST)
    ) u_table (
        .step  (st),
        .addr  (spi_addr),
        .wdata (spi_wdata)
    );

    dac_bringup_timer #(.W(SW)) u_settle (
        .clk     (clk),
        .rst     (rst),
        .ld      (retime),
        .ld_val  (SETTLE_LD),
        .expired (settle_done)
    );

    dac_bringup_timer #(.W(TW)) u_acktmo (
        .clk     (clk),
        .rst     (rst),
        .ld      (retime),
        .ld_val  (ACK_LD),
        .expired (ack_expired)
    );

    for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
        logic at_poll, in_window, at_cfg;

        assign at_poll   = si.poll && (si.stage == 1'(g));
        assign in_window = (si.settle || si.poll) && (si.stage == 1'(g));
        assign at_cfg    = (st == stage_cfg(1'(g)));

        dac_bringup_tries #(.TRIES(LOCK_TRIES)) u_tries (
            .clk       (clk),
            .rst       (rst),
            .bump      (at_poll && lock_miss),
            .wipe      (at_poll && lock_pass),
            .final_try (last_try[g])
        );

        always_ff @(posedge clk) begin
            if (rst || at_cfg) begin
                irq_seen[g] <= 1'b0;
            end else if (irq_in[g] && in_window) begin
                irq_seen[g] <= 1'b1;
            end
        end
    end

    always_comb begin
        nxt       = st;
        nxt_fail  = FS_NONE;
        lock_pass = 1'b0;
        lock_miss = 1'b0;
        if (si.issue) begin
            if (spi_ack) begin
                if (si.poll) begin
                    if (lock_now) begin
                        lock_pass = 1'b1;
                        nxt       = next_step(st, core_bypass);
                    end else begin
                        lock_miss = 1'b1;
                        if (last_try[si.stage]) begin
                            nxt      = ST_FAULT;
                            nxt_fail = stage_fail(si.stage);
                        end else begin
                            nxt = stage_cfg(si.stage);
                        end
                    end
                end else begin
                    nxt = next_step(st, core_bypass);
                end
            end else if (ack_expired) begin
                nxt      = ST_FAULT;
                nxt_fail = FS_SPI;
            end
        end else if (si.settle && settle_done) begin
            nxt = next_step(st, core_bypass);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_PORT_CFG;
            fail_q <= FS_NONE;
            err_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            st     <= nxt;
            done_q <= (nxt == ST_UP) && (st != ST_UP);
            if (nxt == ST_FAULT && st != ST_FAULT) begin
                err_q  <= 1'b1;
                fail_q <= nxt_fail;
            end
        end
    end

    assign spi_req    = si.issue;
    assign spi_rnw    = si.rnw;
    assign seq_done   = done_q;
    assign seq_err    = err_q;
    assign fail_stage = fail_q;
endmodule

// File: rtl/dac_bringup_seq_chk.sv
module dac_bringup_seq_chk #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          spi_req,
    input logic          spi_ack,
    input logic          spi_rnw,
    input logic [AW-1:0] spi_addr,
    input logic [DW-1:0] spi_wdata,
    input logic          seq_done,
    input logic          seq_err,
    input logic [1:0]    fail_stage
);
    a_r2_hold_cmd: assert property (@(posedge clk) disable iff (rst)
        (spi_req && !spi_ack) |=> (seq_err || (spi_req && $stable(spi_addr)
            && $stable(spi_wdata) && $stable(spi_rnw))));

    a_r2_quiet_after_err: assert property (@(posedge clk) disable iff (rst)
        seq_err |-> !spi_req);

    a_r2_quiet_after_done: assert property (@(posedge clk) disable iff (rst)
        seq_done |-> !spi_req);

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> !seq_done);

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
        seq_err |=> seq_err);

    a_r9_no_done_in_err: assert property (@(posedge clk) disable iff (rst)
        seq_err |-> !seq_done);

    a_r7_code_with_err: assert property (@(posedge clk) disable iff (rst)
        seq_err |-> (fail_stage != 2'd0));

    a_r10_code_clear: assert property (@(posedge clk) disable iff (rst)
        !seq_err |-> (fail_stage == 2'd0));
endmodule

bind dac_bringup_seq dac_bringup_seq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .spi_req    (spi_req),
    .spi_ack    (spi_ack),
    .spi_rnw    (spi_rnw),
    .spi_addr   (spi_addr),
    .spi_wdata  (spi_wdata),
    .seq_done   (seq_done),
    .seq_err    (seq_err),
    .fail_stage (fail_stage)
);

// File: tb/dac_bringup_seq_test.sv
module dac_bringup_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int SETTLE = 40;
    localparam int TMO = 16;
    localparam int LB = 2;
    localparam logic [AW-1:0] A_PORT = 8'h00, A_SRST = 8'h01, A_CMV = 8'h0F, A_MUCFG = 8'h26;
    localparam logic [AW-1:0] A_MUST = 8'h2A, A_CORE = 8'h08, A_RXCFG = 8'h10, A_RXST = 8'h21;
    localparam logic [DW-1:0] V_PORT = 8'h18, V_SRST = 8'h80, V_CMV = 8'h0F, V_MUCFG = 8'h8B;
    localparam logic [DW-1:0] V_CORE = 8'h34, V_RXCFG = 8'h83;

    logic clk = 1'b0, rst = 1'b1, core_bypass = 1'b0, mu_irq = 1'b0, rx_irq = 1'b0;
    logic spi_req, spi_rnw, spi_ack, seq_done, seq_err;
    logic [AW-1:0] spi_addr;
    logic [DW-1:0] spi_wdata, spi_rdata;
    logic [1:0] fail_stage;

    dac_bringup_seq #(
        .AW(AW), .DW(DW), .SETTLE_CYC(SETTLE), .ACK_TIMEOUT(TMO), .LOCK_TRIES(3), .LOCK_BIT(LB),
        .A_PORT(A_PORT), .V_PORT(V_PORT), .A_SRST(A_SRST), .V_SRST(V_SRST),
        .A_CMV(A_CMV), .V_CMV(V_CMV), .A_MUCFG(A_MUCFG), .V_MUCFG(V_MUCFG),
        .A_MUST(A_MUST), .A_CORE(A_CORE), .V_CORE(V_CORE),
        .A_RXCFG(A_RXCFG), .V_RXCFG(V_RXCFG), .A_RXST(A_RXST)
    ) uut (
        .clk(clk), .rst(rst), .core_bypass(core_bypass), .mu_irq(mu_irq), .rx_irq(rx_irq),
        .spi_req(spi_req), .spi_rnw(spi_rnw), .spi_addr(spi_addr), .spi_wdata(spi_wdata),
        .spi_ack(spi_ack), .spi_rdata(spi_rdata), .seq_done(seq_done), .seq_err(seq_err),
        .fail_stage(fail_stage)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int total = 0, bad = 0;
    bit finished = 0;

    // serializer model state
    int ack_dly = 0, stall_idx = -1, mu_fail_n = 0, rx_fail_n = 0;
    int mu_polls = 0, rx_polls = 0, wcnt = 0, cyc = 0, done_cnt = 0, log_n = 0;
    logic [AW-1:0] log_addr [64];
    logic [DW-1:0] log_data [64];
    logic          log_rnw  [64];
    int            log_cyc  [64];
    logic [AW-1:0] exp_addr [64];
    logic [DW-1:0] exp_data [64];
    logic          exp_rnw  [64];
    int            exp_n = 0;

    initial begin
        bit lk;
        spi_ack = 1'b0;
        spi_rdata = '0;
        forever begin
            @(negedge clk);
            cyc++;
            if (seq_done) done_cnt++;
            spi_ack = 1'b0;
            if (!rst && spi_req && log_n != stall_idx && log_n < 64) begin
                if (wcnt >= ack_dly) begin
                    wcnt = 0;
                    spi_ack = 1'b1;
                    log_addr[log_n] = spi_addr;
                    log_data[log_n] = spi_wdata;
                    log_rnw[log_n]  = spi_rnw;
                    log_cyc[log_n]  = cyc;
                    log_n++;
                    if (spi_rnw) begin
                        if (spi_addr == A_MUST) begin
                            lk = (mu_polls >= mu_fail_n);
                            mu_polls++;
                        end else begin
                            lk = (rx_polls >= rx_fail_n);
                            rx_polls++;
                        end
                        spi_rdata = lk ? (DW'(1) << LB) : ~(DW'(1) << LB);
                    end
                end else begin
                    wcnt++;
                end
            end else begin
                wcnt = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic r);
        exp_addr[exp_n] = a;
        exp_data[exp_n] = d;
        exp_rnw[exp_n]  = r;
        exp_n++;
    endtask

    task automatic push_head();
        exp_n = 0;
        push(A_PORT, V_PORT, 1'b0);
        push(A_SRST, V_SRST, 1'b0);
        push(A_CMV, V_CMV, 1'b0);
    endtask

    task automatic cmp_seq(input string tag);
        int bad_at = -1;
        for (int i = 0; i < exp_n && i < log_n; i++) begin
            if (bad_at < 0 && (log_addr[i] !== exp_addr[i] || log_data[i] !== exp_data[i]
                               || log_rnw[i] !== exp_rnw[i])) bad_at = i;
        end
        chk(log_n == exp_n, {tag, " command count"}, log_n, exp_n);
        if (bad_at >= 0)
            chk(1'b0, {tag, " command addr at first mismatch"}, log_addr[bad_at], exp_addr[bad_at]);
        else
            chk(1'b1, tag, 0, 0);
    endtask

    task automatic do_reset(input logic byp, input int mfail, input int rfail, input int dly, input int stall);
        @(posedge clk); #1;
        rst = 1'b1;
        core_bypass = byp;
        mu_irq = 1'b0;
        rx_irq = 1'b0;
        mu_fail_n = mfail; rx_fail_n = rfail; ack_dly = dly; stall_idx = stall;
        mu_polls = 0; rx_polls = 0; log_n = 0; done_cnt = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic run_to_end();
        int n = 0;
        while (!seq_done && !seq_err && n < 5000) begin
            @(posedge clk); #1;
            n++;
        end
        repeat (10) @(posedge clk);
        #1;
    endtask

    task automatic t_reset_state();
        do_reset(1'b0, 0, 0, 0, -1);
        rst = 1'b1;
        @(posedge clk); #1;
        chk(seq_done == 1'b0, "R10 done in reset", seq_done, 0);
        chk(seq_err == 1'b0, "R10 err in reset", seq_err, 0);
        chk(fail_stage == 2'd0, "R10 fail_stage in reset", fail_stage, 0);
        rst = 1'b0;
        chk(spi_req == 1'b1 && spi_addr == A_PORT, "R1 first command after reset", spi_addr, A_PORT);
    endtask

    task automatic t_clean(input int dly);
        do_reset(1'b0, 0, 0, dly, -1);
        run_to_end();
        push_head();
        push(A_MUCFG, V_MUCFG, 1'b0); push(A_MUST, '0, 1'b1);
        push(A_CORE, V_CORE, 1'b0);
        push(A_RXCFG, V_RXCFG, 1'b0); push(A_RXST, '0, 1'b1);
        cmp_seq("R1 R5 clean order");
        chk(done_cnt == 1, "R9 done pulse width", done_cnt, 1);
        chk(seq_err == 1'b0 && fail_stage == 2'd0, "R10 no error on clean run", fail_stage, 0);
        chk(log_cyc[4] - log_cyc[3] == SETTLE + 1 + dly, "R3 mu settle gap",
            log_cyc[4] - log_cyc[3], SETTLE + 1 + dly);
        chk(log_cyc[7] - log_cyc[6] == SETTLE + 1 + dly, "R3 rx settle gap",
            log_cyc[7] - log_cyc[6], SETTLE + 1 + dly);
        chk(spi_req == 1'b0, "R2 quiet after done", spi_req, 0);
    endtask

    task automatic t_bypass();
        do_reset(1'b1, 0, 0, 1, -1);
        run_to_end();
        push_head();
        push(A_MUCFG, V_MUCFG, 1'b0); push(A_MUST, '0, 1'b1);
        push(A_RXCFG, V_RXCFG, 1'b0); push(A_RXST, '0, 1'b1);
        cmp_seq("R5 bypass skips core write");
        chk(done_cnt == 1, "R9 done with bypass", done_cnt, 1);
    endtask

    task automatic t_mu_retry();
        do_reset(1'b0, 2, 0, 0, -1);
        run_to_end();
        push_head();
        for (int i = 0; i < 3; i++) begin
            push(A_MUCFG, V_MUCFG, 1'b0); push(A_MUST, '0, 1'b1);
        end
        push(A_CORE, V_CORE, 1'b0);
        push(A_RXCFG, V_RXCFG, 1'b0); push(A_RXST, '0, 1'b1);
        cmp_seq("R6 mu retried twice");
        chk(done_cnt == 1 && !seq_err, "R6 lock on third attempt", done_cnt, 1);
    endtask

    task automatic t_mu_exhaust();
        int n_before;
        do_reset(1'b0, 3, 0, 0, -1);
        run_to_end();
        push_head();
        for (int i = 0; i < 3; i++) begin
            push(A_MUCFG, V_MUCFG, 1'b0); push(A_MUST, '0, 1'b1);
        end
        cmp_seq("R7 R5 mu exhausted, no receiver command");
        chk(seq_err == 1'b1, "R7 err after third mu failure", seq_err, 1);
        chk(fail_stage == 2'd1, "R7 mu fail code", fail_stage, 1);
        chk(done_cnt == 0, "R9 no done after error", done_cnt, 0);
        n_before = log_n;
        repeat (300) @(posedge clk);
        #1;
        chk(seq_err == 1'b1, "R9 error sticky", seq_err, 1);
        chk(log_n == n_before && spi_req == 1'b0, "R2 no command after error", log_n, n_before);
    endtask

    task automatic t_rx_exhaust();
        do_reset(1'b1, 0, 3, 0, -1);
        run_to_end();
        push_head();
        push(A_MUCFG, V_MUCFG, 1'b0); push(A_MUST, '0, 1'b1);
        for (int i = 0; i < 3; i++) begin
            push(A_RXCFG, V_RXCFG, 1'b0); push(A_RXST, '0, 1'b1);
        end
        cmp_seq("R7 rx exhausted");
        chk(seq_err == 1'b1 && fail_stage == 2'd2, "R7 rx fail code", fail_stage, 2);
    endtask

    task automatic t_split_counts();
        do_reset(1'b1, 1, 2, 0, -1);
        run_to_end();
        chk(done_cnt == 1 && !seq_err, "R6 per-stage attempt counts", seq_err, 0);
        chk(log_n == 3 + 4 + 6, "R6 command count with split failures", log_n, 13);
    endtask

    task automatic t_irq_lock();
        int n = 0;
        do_reset(1'b0, 99, 99, 0, -1);
        while (log_n < 4 && n < 2000) begin @(posedge clk); #1; n++; end
        repeat (5) @(posedge clk);
        #1 mu_irq = 1'b1;
        @(posedge clk); #1 mu_irq = 1'b0;
        n = 0;
        while (log_n < 7 && n < 2000) begin @(posedge clk); #1; n++; end
        repeat (5) @(posedge clk);
        #1 rx_irq = 1'b1;
        @(posedge clk); #1 rx_irq = 1'b0;
        run_to_end();
        chk(done_cnt == 1 && !seq_err, "R4 interrupt accepted as lock", done_cnt, 1);
        chk(log_n == 8, "R4 single attempt per stage with interrupt", log_n, 8);
    endtask

    task automatic t_timeout();
        do_reset(1'b0, 0, 0, 0, 2);
        run_to_end();
        chk(seq_err == 1'b1, "R8 error on missing ack", seq_err, 1);
        chk(fail_stage == 2'd3, "R8 timeout code", fail_stage, 3);
        chk(log_n == 2 && spi_req == 1'b0, "R8 stopped at stalled command", log_n, 2);
        chk(done_cnt == 0, "R9 no done after timeout", done_cnt, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_clean(0);
        t_clean(3);
        t_bypass();
        t_mu_retry();
        t_mu_exhaust();
        t_rx_exhaust();
        t_split_counts();
        t_irq_lock();
        t_timeout();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule